// File: doc/BRIEF.md
# Interlocked Read Handshake Link

This block joins a requesting I/O agent and a memory responder that live in two unrelated clock domains. They share one multiplexed address/data bus and three control lines: a read request, a bidirectional acknowledge, and a data-valid strobe. A read is a fully interlocked exchange. Neither side steps forward on a timer. Each side waits until it has seen the other side's last edge through a two-flop synchronizer. The acknowledge line is used twice in one read. The responder first drives it to accept the address. The requester later drives it to accept the data.

The local user of the requester pulses `start_i` with an address while the link is idle. The link then returns one data word on `rdata_o` together with a single-cycle `done_o` pulse. The responder holds a small word array that is preset at reset from a fixed arithmetic pattern. It waits a programmable number of its own clock cycles before it offers the data. The bus and line values are brought out so that the exchange can be observed.

Requester states: RQ_IDLE (waits for start) → RQ_ADDR (drives request and address, waits for acknowledge) → RQ_ACK_LOW (bus released, waits for acknowledge low) → RQ_WAIT_DATA (waits for data-valid, captures the word) → RQ_ACK (drives acknowledge, waits for data-valid low) → RQ_FINISH (acknowledge released, waits for the line to read low) → RQ_IDLE.
Responder states: RS_IDLE (waits for request, latches the address) → RS_ACK (drives acknowledge, waits for request low) → RS_ACK_CLR (waits for its own acknowledge to read low) → RS_ACCESS (counts the access delay; skipped when the delay is zero) → RS_DRIVE (drives the word and data-valid, waits for acknowledge) → RS_RELEASE (waits for acknowledge low) → RS_IDLE.

Top module: `rdhs_link_top`

## Requirements
- R1: While either reset is held, `done_o`, `busy_o`, all three control lines and `line_bus_drv_o` are 0.
- R2: When `start_i` is high at a requester clock edge while the link is idle, the requester raises the request line and drives the address onto the bus at that edge. Both stay unchanged until the requester sees acknowledge high.
- R3: The responder raises acknowledge only while the request line is high. The requester drops the request line and releases the bus only after it has seen acknowledge high.
- R4: The responder drops acknowledge only after it has seen the request line low.
- R5: Data-valid rises exactly (ACCESS_CYC + 3) responder clock periods after the responder's acknowledge falls. Here 3 counts the two synchronizer stages and one state step. The word is on the bus when data-valid rises, and request and acknowledge are both low at that point.
- R6: The word read for address a is ((a mod DEPTH) * PAT_MUL + PAT_ADD) mod 2^DW. `done_o` is high for exactly one requester cycle, and `rdata_o` carries that word while it is high.
- R7: The control lines change in exactly this order: request↑, ack↑, request↓, ack↓, data-valid↑, ack↑, data-valid↓, ack↓. The responder drops data-valid only after it has seen acknowledge high.
- R8: The two sides never drive the bus at once. The bus is undriven between the address phase and the data phase, and again after data-valid falls.
- R9: `start_i` is ignored while `busy_o` is high. It starts no second read and does not change the address of the read in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dev_clk | input | 1 | Requester clock |
| dev_rst_n | input | 1 | Requester active-low asynchronous reset |
| mem_clk | input | 1 | Responder clock, unrelated to dev_clk |
| mem_rst_n | input | 1 | Responder active-low asynchronous reset |
| start_i | input | 1 | Begin a read (requester domain) |
| addr_i | input | DW | Read address, sampled with start_i |
| busy_o | output | 1 | Requester is inside a transfer |
| done_o | output | 1 | One-cycle pulse: rdata_o is valid |
| rdata_o | output | DW | Returned word |
| line_req_o | output | 1 | Request line |
| line_ack_o | output | 1 | Acknowledge line (driven by either side) |
| line_rdy_o | output | 1 | Data-valid line |
| line_bus_o | output | DW | Shared address/data bus value (0 when undriven) |
| line_bus_drv_o | output | 1 | Some side is driving the bus |

## Verification
The bench sweeps 32 addresses, which wrap around the 16-word array, at two responder clock speeds: one slower than the requester and one faster. It checks every returned word arithmetically. An event monitor follows the eight line edges of each read. A design that skips the wait for its own acknowledge to clear would jump straight to data-valid, and the monitor would flag that as an ordering fault. A wrong delay count shows up as a gap between acknowledge-fall and data-valid-rise that differs from (ACCESS_CYC + 3) periods. A requester that left the bus driven after acknowledge is flagged in the released-bus checks. A second start pulsed during a busy read must leave the result, the done count and the request line untouched; a design that ignored this rule would issue a second read or return the wrong word.

// File: rtl/rdhs_pkg.sv
`timescale 1ns/1ps
package rdhs_pkg;

    typedef enum logic [2:0] {
        RQ_IDLE,
        RQ_ADDR,
        RQ_ACK_LOW,
        RQ_WAIT_DATA,
        RQ_ACK,
        RQ_FINISH
    } rq_state_t;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_ACK,
        RS_ACK_CLR,
        RS_ACCESS,
        RS_DRIVE,
        RS_RELEASE
    } rs_state_t;

endpackage

// File: rtl/rdhs_sync2.sv
`timescale 1ns/1ps
module rdhs_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rdhs_requester.sv
`timescale 1ns/1ps
module rdhs_requester
    import rdhs_pkg::*;
#(
    parameter int DW = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [DW-1:0] addr_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [DW-1:0] rdata_o,
    input  logic          ack_line_i,
    input  logic          rdy_line_i,
    input  logic [DW-1:0] bus_i,
    output logic          req_o,
    output logic          ack_o,
    output logic          bus_en_o,
    output logic [DW-1:0] bus_o
);
    rq_state_t     state_q, state_d;
    logic          ack_s, rdy_s;
    logic [DW-1:0] addr_q;
    logic          capture;

    rdhs_sync2 #(.STAGES(SYNC_STAGES)) u_sync_ack (
        .clk(clk), .rst_n(rst_n), .d_i(ack_line_i), .q_o(ack_s)
    );
    rdhs_sync2 #(.STAGES(SYNC_STAGES)) u_sync_rdy (
        .clk(clk), .rst_n(rst_n), .d_i(rdy_line_i), .q_o(rdy_s)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RQ_IDLE:      if (start_i) state_d = RQ_ADDR;
            RQ_ADDR:      if (ack_s)   state_d = RQ_ACK_LOW;
            RQ_ACK_LOW:   if (!ack_s)  state_d = RQ_WAIT_DATA;
            RQ_WAIT_DATA: if (rdy_s)   state_d = RQ_ACK;
            RQ_ACK:       if (!rdy_s)  state_d = RQ_FINISH;
            RQ_FINISH:    if (!ack_s)  state_d = RQ_IDLE;
            default:                   state_d = RQ_IDLE;
        endcase
    end

    assign capture = (state_q == RQ_WAIT_DATA) && rdy_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // address latch, captured word and done pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            rdata_o <= '0;
            done_o  <= 1'b0;
        end else begin
            if (state_q == RQ_IDLE && start_i) begin
                addr_q <= addr_i;
            end
            if (capture) begin
                rdata_o <= bus_i;
            end
            done_o <= capture;
        end
    end

    // outputs decoded from the state
    always_comb begin
        req_o    = 1'b0;
        ack_o    = 1'b0;
        bus_en_o = 1'b0;
        unique case (state_q)
            RQ_ADDR: begin
                req_o    = 1'b1;
                bus_en_o = 1'b1;
            end
            RQ_ACK:  ack_o = 1'b1;
            default: ;
        endcase
    end

    assign bus_o  = bus_en_o ? addr_q : '0;
    assign busy_o = (state_q != RQ_IDLE);
endmodule

// File: rtl/rdhs_responder.sv
`timescale 1ns/1ps
module rdhs_responder
    import rdhs_pkg::*;
#(
    parameter int DW          = 8,
    parameter int DEPTH       = 16,
    parameter int ACCESS_CYC  = 3,
    parameter int PAT_MUL     = 37,
    parameter int PAT_ADD     = 90,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_line_i,
    input  logic          ack_line_i,
    input  logic [DW-1:0] bus_i,
    output logic          ack_o,
    output logic          rdy_o,
    output logic          bus_en_o,
    output logic [DW-1:0] bus_o
);
    localparam int CW = (ACCESS_CYC < 2) ? 1 : $clog2(ACCESS_CYC);
    localparam logic [CW-1:0] CNT_LAST = CW'((ACCESS_CYC > 0) ? ACCESS_CYC - 1 : 0);

    rs_state_t     state_q, state_d;
    logic          req_s, ack_s;
    logic [DW-1:0] addr_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rd_word;

    rdhs_sync2 #(.STAGES(SYNC_STAGES)) u_sync_req (
        .clk(clk), .rst_n(rst_n), .d_i(req_line_i), .q_o(req_s)
    );
    rdhs_sync2 #(.STAGES(SYNC_STAGES)) u_sync_ack (
        .clk(clk), .rst_n(rst_n), .d_i(ack_line_i), .q_o(ack_s)
    );

    // word array, preset from the arithmetic pattern
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= DW'(i * PAT_MUL + PAT_ADD);
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_q[i];
            end
        end
    end

    // address wraps modulo DEPTH
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if ((addr_q % DW'(DEPTH)) == DW'(i)) begin
                rd_word = mem_q[i];
            end
        end
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE:    if (req_s)  state_d = RS_ACK;
            RS_ACK:     if (!req_s) state_d = RS_ACK_CLR;
            RS_ACK_CLR: if (!ack_s) state_d = (ACCESS_CYC == 0) ? RS_DRIVE : RS_ACCESS;
            RS_ACCESS:  if (cnt_q == CNT_LAST) state_d = RS_DRIVE;
            RS_DRIVE:   if (ack_s)  state_d = RS_RELEASE;
            RS_RELEASE: if (!ack_s) state_d = RS_IDLE;
            default:                state_d = RS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // address latch and delay counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (state_q == RS_IDLE && req_s) begin
                addr_q <= bus_i;
            end
            if (state_q == RS_ACCESS) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        ack_o    = 1'b0;
        rdy_o    = 1'b0;
        bus_en_o = 1'b0;
        unique case (state_q)
            RS_ACK:   ack_o = 1'b1;
            RS_DRIVE: begin
                rdy_o    = 1'b1;
                bus_en_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign bus_o = bus_en_o ? rd_word : '0;
endmodule

// File: rtl/rdhs_link_top.sv
`timescale 1ns/1ps
module rdhs_link_top #(
    parameter int DW          = 8,
    parameter int DEPTH       = 16,
    parameter int ACCESS_CYC  = 3,
    parameter int PAT_MUL     = 37,
    parameter int PAT_ADD     = 90,
    parameter int SYNC_STAGES = 2
) (
    input  logic          dev_clk,
    input  logic          dev_rst_n,
    input  logic          mem_clk,
    input  logic          mem_rst_n,
    input  logic          start_i,
    input  logic [DW-1:0] addr_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [DW-1:0] rdata_o,
    output logic          line_req_o,
    output logic          line_ack_o,
    output logic          line_rdy_o,
    output logic [DW-1:0] line_bus_o,
    output logic          line_bus_drv_o
);
    logic          dev_ack_en, mem_ack_en;
    logic          dev_bus_en, mem_bus_en;
    logic [DW-1:0] dev_bus, mem_bus;

    rdhs_requester #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_dev (
        .clk(dev_clk), .rst_n(dev_rst_n),
        .start_i(start_i), .addr_i(addr_i),
        .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
        .ack_line_i(line_ack_o), .rdy_line_i(line_rdy_o), .bus_i(line_bus_o),
        .req_o(line_req_o), .ack_o(dev_ack_en),
        .bus_en_o(dev_bus_en), .bus_o(dev_bus)
    );

    rdhs_responder #(
        .DW(DW), .DEPTH(DEPTH), .ACCESS_CYC(ACCESS_CYC),
        .PAT_MUL(PAT_MUL), .PAT_ADD(PAT_ADD), .SYNC_STAGES(SYNC_STAGES)
    ) u_mem (
        .clk(mem_clk), .rst_n(mem_rst_n),
        .req_line_i(line_req_o), .ack_line_i(line_ack_o), .bus_i(line_bus_o),
        .ack_o(mem_ack_en), .rdy_o(line_rdy_o),
        .bus_en_o(mem_bus_en), .bus_o(mem_bus)
    );

    // the shared lines: each driver contributes only in its owning states
    assign line_ack_o     = dev_ack_en | mem_ack_en;
    assign line_bus_drv_o = dev_bus_en | mem_bus_en;
    assign line_bus_o     = dev_bus_en ? dev_bus : (mem_bus_en ? mem_bus : '0);
endmodule

// File: rtl/rdhs_link_chk.sv
`timescale 1ns/1ps
module rdhs_link_chk #(
    parameter int DW = 8
) (
    input logic          dev_clk,
    input logic          dev_rst_n,
    input logic          mem_clk,
    input logic          mem_rst_n,
    input logic          busy_o,
    input logic          done_o,
    input logic          line_req_o,
    input logic          line_ack_o,
    input logic          line_rdy_o,
    input logic [DW-1:0] line_bus_o,
    input logic          dev_bus_en,
    input logic          mem_bus_en,
    input logic          mem_ack_en
);
    always @(posedge dev_clk) begin
        if (!dev_rst_n) begin
            AST_IDLE_IN_RESET: assert (!done_o && !busy_o && !dev_bus_en); // R1
        end
    end

    AST_ADDR_HELD: assert property (@(posedge dev_clk) disable iff (!dev_rst_n)
        (line_req_o && $past(line_req_o)) |-> $stable(line_bus_o)); // R2

    AST_REQ_DROP_ACKED: assert property (@(posedge dev_clk) disable iff (!dev_rst_n || !mem_rst_n)
        $fell(line_req_o) |-> line_ack_o); // R3

    AST_ACK_RISE_REQ: assert property (@(posedge mem_clk) disable iff (!dev_rst_n || !mem_rst_n)
        $rose(mem_ack_en) |-> $past(line_req_o)); // R3

    AST_ACK_DROP_NOREQ: assert property (@(posedge mem_clk) disable iff (!dev_rst_n || !mem_rst_n)
        $fell(mem_ack_en) |-> !$past(line_req_o)); // R4

    AST_RDY_QUIET: assert property (@(posedge mem_clk) disable iff (!dev_rst_n || !mem_rst_n)
        $rose(line_rdy_o) |-> (!$past(line_req_o) && !$past(line_ack_o))); // R5

    AST_DONE_PULSE: assert property (@(posedge dev_clk) disable iff (!dev_rst_n)
        done_o |=> !done_o); // R6

    AST_RDY_DROP_ACKED: assert property (@(posedge mem_clk) disable iff (!dev_rst_n || !mem_rst_n)
        $fell(line_rdy_o) |-> $past(line_ack_o)); // R7

    AST_ONE_DRIVER_DEV: assert property (@(posedge dev_clk) disable iff (!dev_rst_n)
        !(dev_bus_en && mem_bus_en)); // R8

    AST_ONE_DRIVER_MEM: assert property (@(posedge mem_clk) disable iff (!mem_rst_n)
        !(dev_bus_en && mem_bus_en)); // R8
endmodule

bind rdhs_link_top rdhs_link_chk #(.DW(DW)) u_chk (
    .dev_clk(dev_clk), .dev_rst_n(dev_rst_n),
    .mem_clk(mem_clk), .mem_rst_n(mem_rst_n),
    .busy_o(busy_o), .done_o(done_o),
    .line_req_o(line_req_o), .line_ack_o(line_ack_o), .line_rdy_o(line_rdy_o),
    .line_bus_o(line_bus_o),
    .dev_bus_en(dev_bus_en), .mem_bus_en(mem_bus_en), .mem_ack_en(mem_ack_en)
);

// File: tb/rdhs_link_top_tb_top.sv
`timescale 1ns/1ps
module rdhs_link_top_tb_top;
    localparam int DW = 8, DEPTH = 16, ACC = 3, PMUL = 37, PADD = 90;

    logic          dev_clk = 1'b0, mem_clk = 1'b0;
    logic          dev_rst_n = 1'b0, mem_rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [DW-1:0] addr_i = '0;
    logic          busy_o, done_o, line_req_o, line_ack_o, line_rdy_o, line_bus_drv_o;
    logic [DW-1:0] rdata_o, line_bus_o;

    real mem_half = 3.3;
    int  checks = 0, errors = 0, dones = 0, completed = 0, ph = 0;
    bit  mon_en = 1'b0, finished = 1'b0;
    logic [DW-1:0] cur_addr = '0;
    realtime t_ackfall = 0.0;

    rdhs_link_top #(.DW(DW), .DEPTH(DEPTH), .ACCESS_CYC(ACC), .PAT_MUL(PMUL), .PAT_ADD(PADD)) dut_i (
        .dev_clk(dev_clk), .dev_rst_n(dev_rst_n), .mem_clk(mem_clk), .mem_rst_n(mem_rst_n),
        .start_i(start_i), .addr_i(addr_i), .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
        .line_req_o(line_req_o), .line_ack_o(line_ack_o), .line_rdy_o(line_rdy_o),
        .line_bus_o(line_bus_o), .line_bus_drv_o(line_bus_drv_o)
    );

    always #2 dev_clk = ~dev_clk;
    initial begin
        #0.37;
        forever #(mem_half) mem_clk = ~mem_clk;
    end

    function automatic logic [DW-1:0] fword(input logic [DW-1:0] a);
        return DW'((int'(a) % DEPTH) * PMUL + PADD);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $realtime);
        end
    endtask

    always @(negedge dev_clk) if (done_o) dones++;

    // line-edge monitor: follows the eight edges of each read
    logic [2:0] prev_lines = 3'b000;
    always @(line_req_o or line_ack_o or line_rdy_o) begin
        if (mon_en) begin
            logic [2:0] now_l, exp_l;
            now_l = {line_req_o, line_ack_o, line_rdy_o};
            case (ph)
                0: exp_l = 3'b100;  1: exp_l = 3'b110;
                2: exp_l = 3'b010;  3: exp_l = 3'b000;
                4: exp_l = 3'b001;  5: exp_l = 3'b011;
                6: exp_l = 3'b010;  default: exp_l = 3'b000;
            endcase
            if (now_l != prev_lines) begin
                prev_lines = now_l;
                chk(now_l == exp_l, "R7 edge order", int'(now_l), int'(exp_l));
                case (ph)
                    0: begin #0.1; chk(line_bus_drv_o && line_bus_o == cur_addr, "R2 address on bus", int'(line_bus_o), int'(cur_addr)); end
                    2: begin #0.1; chk(!line_bus_drv_o, "R8 bus released after address", int'(line_bus_drv_o), 0); end
                    3: t_ackfall = $realtime;
                    4: begin
                        realtime gap, want;
                        gap  = $realtime - t_ackfall;
                        want = (ACC + 3) * 2.0 * mem_half;
                        chk(gap > want - 0.05 && gap < want + 0.05, "R5 access delay (ps)", int'(gap * 1000), int'(want * 1000));
                        #0.1; chk(line_bus_o == fword(cur_addr), "R5 word on bus", int'(line_bus_o), int'(fword(cur_addr)));
                    end
                    6: begin #0.1; chk(!line_bus_drv_o, "R8 bus released after data", int'(line_bus_drv_o), 0); end
                    7: completed++;
                    default: ;
                endcase
                ph = (ph + 1) % 8;
            end
        end
    end

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge dev_clk);
            if (done_o) begin ok = 1'b1; break; end
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            if (!busy_o && !line_ack_o && !line_rdy_o) break;
            @(negedge dev_clk);
        end
    endtask

    task automatic do_read(input logic [DW-1:0] a);
        bit ok;
        cur_addr = a;
        @(negedge dev_clk);
        start_i = 1'b1; addr_i = a;
        @(negedge dev_clk);
        start_i = 1'b0; addr_i = ~a;
        chk(busy_o && line_req_o, "R2 request raised", int'({busy_o, line_req_o}), 3);
        wait_done(ok);
        chk(ok, "R6 done seen", int'(ok), 1);
        if (ok) begin
            chk(rdata_o == fword(a), "R6 returned word", int'(rdata_o), int'(fword(a)));
            @(negedge dev_clk);
            chk(!done_o, "R6 done one cycle", int'(done_o), 0);
        end
        wait_idle();
    endtask

    initial begin
        repeat (8) @(negedge dev_clk);
        chk(!done_o && !busy_o, "R1 requester quiet", int'({done_o, busy_o}), 0);
        chk(!line_req_o && !line_ack_o && !line_rdy_o, "R1 lines quiet",
            int'({line_req_o, line_ack_o, line_rdy_o}), 0);
        chk(!line_bus_drv_o, "R1 bus undriven", int'(line_bus_drv_o), 0);
        mem_rst_n = 1'b1;
        @(negedge dev_clk);
        dev_rst_n = 1'b1;
        mon_en = 1'b1;
        repeat (4) @(negedge dev_clk);

        for (int p = 0; p < 2; p++) begin
            mem_half = (p == 0) ? 3.3 : 1.3;
            repeat (10) @(negedge dev_clk);
            for (int a = 0; a < 32; a++) do_read(DW'((p == 0) ? a : 31 - a));
        end
        chk(completed == 64, "R7 full handshakes", completed, 64);

        // R9: start pulses while busy must be ignored
        begin
            int d0, c0;
            bit ok;
            d0 = dones; c0 = completed;
            cur_addr = 8'd5;
            @(negedge dev_clk); start_i = 1'b1; addr_i = 8'd5;
            @(negedge dev_clk); start_i = 1'b0;
            repeat (3) @(negedge dev_clk);
            for (int k = 0; k < 4; k++) begin
                start_i = 1'b1; addr_i = 8'd9;
                @(negedge dev_clk);
            end
            start_i = 1'b0;
            wait_done(ok);
            chk(ok && rdata_o == fword(8'd5), "R9 address unchanged by busy start", int'(rdata_o), int'(fword(8'd5)));
            wait_idle();
            repeat (60) @(negedge dev_clk);
            chk(dones - d0 == 1, "R9 single done", dones - d0, 1);
            chk(completed - c0 == 1 && !line_req_o, "R9 no second read", completed - c0, 1);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge dev_clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog R6: actual %0d expected %0d", completed, 65);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule